// File: doc/BRIEF.md
# Two-Wire Slave Write Receiver

This block is the receiving end of a two-wire serial bus for writes into a non-volatile store. It watches the synchronized clock and data lines for start and stop conditions. It takes in a device address byte, then a 16-bit word address sent as two bytes, then any number of data bytes. It pulls the data line low to acknowledge each byte it accepts. The word address and each data byte go out on simple valid-qualified outputs to a downstream page buffer. The buffer owns the address increment and the page roll-over.

When the transfer ends, the block decides whether the write may be committed. That decision depends on where the stop lands within the byte and acknowledge framing, and on whether the word address falls in a protected window. A committed write starts an internal write cycle of a parameterized number of clocks. For that whole time the block leaves the data line released and ignores the bus. Any other ending of a transfer is reported as an abort, so the page buffer can throw away what it collected.

Top module: `twi_wr_front`

## Requirements
- R1: After reset, `sda_oe_o`, `busy_o` and every pulse output are low.
- R2: A start is SDA falling while SCL is high. The first byte after a start is taken MSB first: seven address bits, then a direction bit. When the seven bits equal `DEV_ADDR` and the direction bit is 0, the block acknowledges by holding `sda_oe_o` high through the ninth clock. Otherwise it does not acknowledge and ignores the bus until the next start.
- R3: The next two bytes are the word address, high byte first. Each is acknowledged. `waddr_o` is presented with a one-cycle `waddr_vld_o` pulse once the low byte has been received.
- R4: Each following byte, taken MSB first, is acknowledged and presented on `wdata_o` with a one-cycle `wdata_vld_o` pulse, in arrival order.
- R5: A stop is SDA rising while SCL is high. A stop that arrives at a byte boundary, after at least one complete data byte and its acknowledge clock, gives one `commit_o` pulse unless R10 applies.
- R6: A stop that arrives before the first data byte and its acknowledge are complete, or in the middle of a data byte, gives one `abort_o` pulse. It gives no commit and starts no write cycle.
- R7: A start during an unfinished transfer gives one `abort_o` pulse, commits nothing, and begins decoding a new transfer.
- R8: A commit holds `busy_o` high for exactly `WR_CYCLES` clocks, beginning the cycle after `commit_o`.
- R9: While `busy_o` is high, the block never drives `sda_oe_o`, acknowledges nothing, and ignores starts, stops and bytes.
- R10: When `prot_en_i` is high and the word address lies within `PROT_LO`..`PROT_HI` inclusive, every byte is still acknowledged. An otherwise valid stop then gives `abort_o` instead of `commit_o` and no busy period, and later transfers are acknowledged normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| prot_en_i | input | 1 | Enables the protected address window |
| sda_oe_o | output | 1 | Pull the data line low (acknowledge) |
| waddr_o | output | 16 | Received word address |
| waddr_vld_o | output | 1 | Pulse: word address valid |
| wdata_o | output | 8 | Received data byte |
| wdata_vld_o | output | 1 | Pulse: data byte valid |
| commit_o | output | 1 | Pulse: write may be committed |
| abort_o | output | 1 | Pulse: transfer discarded |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
Every line event passes through two synchronizer flops and one history flop, and the next-state register adds one more. An acknowledge, a valid pulse, a commit or an abort is therefore due three to four clocks after the bus edge that causes it. The bench holds every bus phase for eight clocks. It samples the acknowledge in the middle of the ninth clock's high phase, and it reads the pulse counters only after the phase that follows the triggering edge has ended. The busy length is measured by a falling-edge monitor that counts consecutive high cycles and compares them with `WR_CYCLES` after the busy window has closed.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WADDR_W = 2 * BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_WAH,
        ST_ACK_WAH,
        ST_WAL,
        ST_ACK_WAL,
        ST_DATA,
        ST_ACK_DATA
    } rx_state_t;

    typedef struct packed {
        rx_state_t          state;
        logic [2:0]         bitcnt;
        logic               byte_done;
        logic [BYTE_W-1:0]  shreg;
        logic               oe;
        logic [WADDR_W-1:0] waddr;
        logic               waddr_vld;
        logic [BYTE_W-1:0]  data;
        logic               data_vld;
        logic               data_seen;
        logic               commit;
        logic               abort;
    } rx_regs_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int unsigned DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_d, scl_q;
    logic [DEPTH-1:0] sda_d, sda_q;

    logic scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        scl_d = {scl_q[DEPTH-2:0], scl_i};
        sda_d = {sda_q[DEPTH-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    always_comb begin
        scl_now    = scl_q[SYNC_STAGES-1];
        scl_old    = scl_q[SYNC_STAGES];
        sda_now    = sda_q[SYNC_STAGES-1];
        sda_old    = sda_q[SYNC_STAGES];
        sda_s_o    = sda_now;
        scl_rise_o = scl_now & ~scl_old;
        scl_fall_o = ~scl_now & scl_old;
        start_o    = scl_now & scl_old & sda_old & ~sda_now;
        stop_o     = scl_now & scl_old & ~sda_old & sda_now;
    end

endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
    parameter int unsigned WR_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    localparam int unsigned CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CW'(WR_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/twi_wr_fsm.sv
module twi_wr_fsm
    import twi_pkg::*;
#(
    parameter logic [6:0]         DEV_ADDR = 7'h57,
    parameter logic [WADDR_W-1:0] PROT_LO  = 16'h0100,
    parameter logic [WADDR_W-1:0] PROT_HI  = 16'h01FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               busy_i,
    input  logic               prot_en_i,
    output logic               sda_oe_o,
    output logic [WADDR_W-1:0] waddr_o,
    output logic               waddr_vld_o,
    output logic [BYTE_W-1:0]  wdata_o,
    output logic               wdata_vld_o,
    output logic               commit_o,
    output logic               abort_o
);

    rx_regs_t d, q;
    logic     stop_ok;
    logic     prot_hit;

    always_comb begin
        d           = q;
        d.waddr_vld = 1'b0;
        d.data_vld  = 1'b0;
        d.commit    = 1'b0;
        d.abort     = 1'b0;

        stop_ok  = (q.state == ST_DATA) && q.data_seen && !q.byte_done
                   && (q.bitcnt <= 3'd1);
        prot_hit = prot_en_i && (q.waddr >= PROT_LO) && (q.waddr <= PROT_HI);

        if (busy_i) begin
            d.state     = ST_IDLE;
            d.oe        = 1'b0;
            d.bitcnt    = '0;
            d.byte_done = 1'b0;
            d.data_seen = 1'b0;
        end else if (start_i) begin
            d.abort     = (q.state != ST_IDLE);
            d.state     = ST_DEV;
            d.oe        = 1'b0;
            d.bitcnt    = '0;
            d.byte_done = 1'b0;
            d.data_seen = 1'b0;
        end else if (stop_i) begin
            if (q.state != ST_IDLE) begin
                if (stop_ok && !prot_hit) d.commit = 1'b1;
                else                      d.abort  = 1'b1;
            end
            d.state     = ST_IDLE;
            d.oe        = 1'b0;
            d.bitcnt    = '0;
            d.byte_done = 1'b0;
            d.data_seen = 1'b0;
        end else begin
            unique case (q.state)
                ST_DEV, ST_WAH, ST_WAL, ST_DATA: begin
                    if (scl_rise_i && !q.byte_done) begin
                        d.shreg     = {q.shreg[BYTE_W-2:0], sda_i};
                        d.bitcnt    = q.bitcnt + 3'd1;
                        d.byte_done = (q.bitcnt == 3'd7);
                    end else if (scl_fall_i && q.byte_done) begin
                        d.byte_done = 1'b0;
                        d.bitcnt    = '0;
                        d.oe        = 1'b1;
                        unique case (q.state)
                            ST_DEV: begin
                                if (q.shreg[7:1] == DEV_ADDR && !q.shreg[0]) begin
                                    d.state = ST_ACK_DEV;
                                end else begin
                                    d.state = ST_IDLE;
                                    d.oe    = 1'b0;
                                end
                            end
                            ST_WAH: begin
                                d.waddr[WADDR_W-1:BYTE_W] = q.shreg;
                                d.state = ST_ACK_WAH;
                            end
                            ST_WAL: begin
                                d.waddr[BYTE_W-1:0] = q.shreg;
                                d.waddr_vld = 1'b1;
                                d.state = ST_ACK_WAL;
                            end
                            default: begin
                                d.data     = q.shreg;
                                d.data_vld = 1'b1;
                                d.state    = ST_ACK_DATA;
                            end
                        endcase
                    end
                end
                ST_ACK_DEV, ST_ACK_WAH, ST_ACK_WAL, ST_ACK_DATA: begin
                    if (scl_fall_i) begin
                        d.oe = 1'b0;
                        unique case (q.state)
                            ST_ACK_DEV: d.state = ST_WAH;
                            ST_ACK_WAH: d.state = ST_WAL;
                            ST_ACK_WAL: d.state = ST_DATA;
                            default: begin
                                d.state     = ST_DATA;
                                d.data_seen = 1'b1;
                            end
                        endcase
                    end
                end
                default: begin
                    d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign waddr_o     = q.waddr;
    assign waddr_vld_o = q.waddr_vld;
    assign wdata_o     = q.data;
    assign wdata_vld_o = q.data_vld;
    assign commit_o    = q.commit;
    assign abort_o     = q.abort;

    AST_DEV_ACK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ACK_DEV) |-> (q.oe && $past(q.shreg[7:1]) == DEV_ADDR)); // R2
    AST_ADDR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        q.waddr_vld |-> q.oe); // R3
    AST_DATA_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        q.data_vld |-> q.oe); // R4
    AST_COMMIT_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |-> $past(q.data_seen)); // R5
    AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !q.oe); // R9

endmodule

// File: rtl/twi_wr_front.sv
module twi_wr_front
    import twi_pkg::*;
#(
    parameter logic [6:0]         DEV_ADDR    = 7'h57,
    parameter logic [WADDR_W-1:0] PROT_LO     = 16'h0100,
    parameter logic [WADDR_W-1:0] PROT_HI     = 16'h01FF,
    parameter int unsigned        WR_CYCLES   = 500,
    parameter int unsigned        SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        prot_en_i,
    output logic        sda_oe_o,
    output logic [15:0] waddr_o,
    output logic        waddr_vld_o,
    output logic [7:0]  wdata_o,
    output logic        wdata_vld_o,
    output logic        commit_o,
    output logic        abort_o,
    output logic        busy_o
);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s_o   (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    twi_wr_fsm #(
        .DEV_ADDR(DEV_ADDR),
        .PROT_LO (PROT_LO),
        .PROT_HI (PROT_HI)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .busy_i     (busy_o),
        .prot_en_i  (prot_en_i),
        .sda_oe_o   (sda_oe_o),
        .waddr_o    (waddr_o),
        .waddr_vld_o(waddr_vld_o),
        .wdata_o    (wdata_o),
        .wdata_vld_o(wdata_vld_o),
        .commit_o   (commit_o),
        .abort_o    (abort_o)
    );

    twi_busy_timer #(
        .WR_CYCLES(WR_CYCLES)
    ) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(commit_o),
        .busy_o(busy_o)
    );

    AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> busy_o); // R8
    AST_ABORT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !busy_o); // R6
    AST_ONE_ENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && abort_o)); // R7

endmodule

// File: tb/twi_wr_front_tb.sv
module twi_wr_front_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          Q          = 8;
    localparam int          WR_CYC     = 400;
    localparam logic [6:0]  DEV        = 7'h57;
    localparam logic [15:0] P_LO       = 16'h0100;
    localparam logic [15:0] P_HI       = 16'h01FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic prot_en = 1'b0;
    logic sda_line;
    logic sda_oe, waddr_vld, wdata_vld, commit, abort_p, busy;
    logic [15:0] waddr;
    logic [7:0]  wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twi_wr_front #(
        .DEV_ADDR(DEV), .PROT_LO(P_LO), .PROT_HI(P_HI), .WR_CYCLES(WR_CYC), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .prot_en_i(prot_en),
        .sda_oe_o(sda_oe), .waddr_o(waddr), .waddr_vld_o(waddr_vld), .wdata_o(wdata),
        .wdata_vld_o(wdata_vld), .commit_o(commit), .abort_o(abort_p), .busy_o(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Monitor, sampling at the falling clock edge.
    int          waddr_cnt = 0;
    logic [15:0] last_waddr = '0;
    int          n_data = 0;
    logic [7:0]  got_data [0:1023];
    int          commit_cnt = 0;
    int          abort_cnt = 0;
    int          busy_run = 0;
    int          last_busy_len = 0;
    int          oe_busy = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (waddr_vld) begin waddr_cnt++; last_waddr = waddr; end
            if (wdata_vld) begin got_data[n_data & 1023] = wdata; n_data++; end
            if (commit) commit_cnt++;
            if (abort_p) abort_cnt++;
            if (busy && sda_oe) oe_busy++;
            if (busy) busy_run++;
            else if (busy_run != 0) begin last_busy_len = busy_run; busy_run = 0; end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b1; wclk(Q);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q/2);
        ack = (sda_line == 1'b0);
        wclk(Q/2);
        scl_m = 1'b0; wclk(Q);
    endtask

    function automatic bit exp_prot(input logic [15:0] a, input bit en);
        return en && (a >= P_LO) && (a <= P_HI);
    endfunction

    // One addressed write with nb data bytes; ends in a stop when do_stop is set.
    task automatic full_write(input logic [15:0] a, input int nb, input bit do_stop);
        bit ack;
        int c0, a0, d0, w0;
        bit prot;
        logic [7:0] exp_d [0:31];
        prot = exp_prot(a, prot_en);
        bus_start();
        c0 = commit_cnt; a0 = abort_cnt; d0 = n_data; w0 = waddr_cnt;
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R2 device address ack", ack, 1);
        send_byte(a[15:8], ack);
        chk(ack, "R3 high word address ack", ack, 1);
        send_byte(a[7:0], ack);
        chk(ack, "R3 low word address ack", ack, 1);
        chk(waddr_cnt == w0 + 1 && last_waddr == a, "R3 word address out",
            int'(last_waddr), int'(a));
        for (int i = 0; i < nb; i++) begin
            exp_d[i] = 8'($urandom);
            send_byte(exp_d[i], ack);
            chk(ack, "R4 data byte ack", ack, 1);
        end
        chk(n_data == d0 + nb, "R4 data byte count", n_data - d0, nb);
        for (int i = 0; i < nb; i++)
            chk(got_data[(d0 + i) & 1023] == exp_d[i], "R4 data byte value",
                int'(got_data[(d0 + i) & 1023]), int'(exp_d[i]));
        if (do_stop) begin
            bus_stop();
            wclk(2);
            if (prot) begin
                chk(commit_cnt == c0, "R10 protected no commit", commit_cnt - c0, 0);
                chk(abort_cnt == a0 + 1, "R10 protected abort", abort_cnt - a0, 1);
                chk(busy == 1'b0, "R10 protected no busy", busy, 0);
            end else begin
                chk(commit_cnt == c0 + 1, "R5 commit on valid stop", commit_cnt - c0, 1);
                chk(abort_cnt == a0, "R5 no abort on valid stop", abort_cnt - a0, 0);
                chk(busy == 1'b1, "R8 busy after commit", busy, 1);
                wclk(WR_CYC + 4);
                chk(busy == 1'b0 && last_busy_len == WR_CYC, "R8 busy length",
                    last_busy_len, WR_CYC);
            end
        end
    endtask

    initial begin
        bit ack;
        int c0, a0, w0;
        logic [15:0] ra;
        void'($urandom(32'd20240611));
        wclk(4);
        chk(sda_oe == 1'b0 && busy == 1'b0 && commit == 1'b0 && abort_p == 1'b0
            && waddr_vld == 1'b0 && wdata_vld == 1'b0, "R1 reset outputs", sda_oe, 0);
        rst_n = 1'b1;
        wclk(4);

        // Basic write with a page-sized payload.
        full_write(16'h0010, 16, 1'b1);

        // Wrong device address: no ack, later bytes ignored.
        bus_start();
        a0 = abort_cnt; w0 = waddr_cnt;
        send_byte({7'h23, 1'b0}, ack);
        chk(!ack, "R2 wrong address nack", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R2 ignored until next start", ack, 0);
        bus_stop(); wclk(2);
        chk(waddr_cnt == w0 && abort_cnt == a0, "R2 no activity after nack",
            abort_cnt - a0, 0);

        // Read direction: not acknowledged.
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        chk(!ack, "R2 read direction nack", ack, 0);
        bus_stop(); wclk(2);

        // Stop right after the word address: discarded.
        c0 = commit_cnt; a0 = abort_cnt;
        full_write(16'h0040, 0, 1'b0);
        bus_stop(); wclk(2);
        chk(commit_cnt == c0 && abort_cnt == a0 + 1, "R6 stop before data aborts",
            abort_cnt - a0, 1);
        chk(busy == 1'b0, "R6 no busy after early stop", busy, 0);

        // Stop in the middle of the second data byte.
        c0 = commit_cnt; a0 = abort_cnt;
        full_write(16'h0050, 1, 1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop(); wclk(2);
        chk(commit_cnt == c0 && abort_cnt == a0 + 1, "R6 stop mid byte aborts",
            abort_cnt - a0, 1);
        chk(busy == 1'b0, "R6 no busy after mid-byte stop", busy, 0);

        // Repeated start in the middle of a frame.
        c0 = commit_cnt; a0 = abort_cnt;
        full_write(16'h0060, 2, 1'b0);
        send_bit(1'b1); send_bit(1'b0);
        full_write(16'h0070, 2, 1'b1);
        chk(commit_cnt == c0 + 1 && abort_cnt == a0 + 1, "R7 restart aborts first",
            abort_cnt - a0, 1);

        // Protected window, then a normal write is still acknowledged.
        prot_en = 1'b1;
        full_write(16'h0180, 3, 1'b1);
        full_write(16'h0200, 2, 1'b1);
        prot_en = 1'b0;

        // Deaf while busy: commit, then try to talk during the write cycle.
        full_write(16'h0033, 1, 1'b0);
        bus_stop(); wclk(2);
        chk(busy == 1'b1, "R9 busy after commit", busy, 1);
        a0 = abort_cnt; w0 = waddr_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        chk(!ack, "R9 no ack while busy", ack, 0);
        bus_stop(); wclk(2);
        chk(abort_cnt == a0 && waddr_cnt == w0, "R9 bus ignored while busy",
            abort_cnt - a0, 0);
        wclk(WR_CYC);
        chk(oe_busy == 0, "R9 data line released while busy", oe_busy, 0);

        // Random writes, some into the protected window.
        for (int k = 0; k < 12; k++) begin
            prot_en = 1'($urandom);
            ra = 16'($urandom);
            if ((k % 3) == 0) ra = {8'h01, ra[7:0]};
            full_write(ra, 1 + int'($urandom % 18), 1'b1);
        end
        prot_en = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule